// File: doc/BRIEF.md
# Asynchronous-to-Synchronous Character Converter

This block sits between a start/stop serial line from user equipment and a fixed-rate synchronous channel. It samples the incoming line on a per-channel enable running at sixteen times the configured baud rate. It validates each start bit at mid-bit and collects the whole character into a shallow character buffer. The network side pulls the characters out again one bit at a time. Each channel of a multi-channel system gets its own instance.

The synchronous side works as a stream. `s_valid` rises once reset is released and stays high, so the stream never runs dry. Whenever no character is waiting, mark (1) bits fill the gap. The consumer applies back-pressure by holding `s_ready` low, and exactly one bit is consumed on each cycle with `s_ready` high. When the line side runs slightly faster than the network side, the buffer fills. The converter then shortens a character by dropping its final stop element, at a rate limited to one character in every eight. If a character still arrives with the buffer full, it is discarded and a sticky overflow flag records the loss. There are no modem control inputs, and the line side has no handshake.

Top module: `a2s_converter`

## Requirements
- R1: A falling edge seen on the synchronised line (on a `baud_en` sample) opens a start bit only if the line is still low at the 8th following enable; otherwise the edge is discarded, no character is produced, and the output stays at mark.
- R2: After a valid start, one sample is taken every 16 enables. The character length, counting the start bit, is chosen by `len_sel`: code 0 gives 9 bits, code 1 gives 10 bits, and codes 2 and 3 give 11 bits. The start bit is character bit 0, and the final bit is the stop element.
- R3: Characters leave on `s_bit` in arrival order, bit 0 first, one bit per cycle with `s_ready` high. They carry exactly the sampled values. `s_bit` holds its value while `s_ready` is low.
- R4: When a bit is pulled and no character is in progress or waiting, `s_bit` is 1.
- R5: A character whose final sample is 0 raises `frame_err` for exactly one cycle. The character is still forwarded with its low final bit intact.
- R6: When a character starts leaving while the buffer holds at least DEPTH-1 characters, its final bit is 1, and at least 7 complete characters have left since the previous shortened one, that final bit is not sent. The next character's start bit follows directly.
- R7: A character completed while the buffer already holds DEPTH characters is discarded, and `ovf_sticky` goes high. The flag stays high until a cycle with `ovf_clr` high and no new overflow in that same cycle; it is low from the next cycle on.
- R8: During reset, `s_bit` is 1 and `s_valid`, `ovf_sticky` and `frame_err` are 0. After reset, `s_valid` goes high and stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_en | input | 1 | One-cycle pulse at 16x the baud rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| len_sel | input | 2 | Character length code (0:9, 1:10, 2/3:11 bits) |
| s_ready | input | 1 | Consumer takes one bit this cycle |
| s_valid | output | 1 | Synchronous stream valid, high after reset |
| s_bit | output | 1 | Synchronous output bit |
| frame_err | output | 1 | One-cycle pulse on a low final sample |
| ovf_sticky | output | 1 | Sticky buffer overflow flag |
| ovf_clr | input | 1 | Clears the overflow flag |

## Verification
The hardest state to reach is stop-element deletion. It needs two things to line up: the buffer must already hold DEPTH-1 characters at the moment a new character starts leaving, and the spacing credit must be available at that moment. The stimulus reaches this state in two steps. First it stalls the consumer while three characters arrive. It then resumes pulling at 33 cycles per bit against a 32-cycle input bit, with short line gaps, so the input stays slightly faster than the output. The monitor in the scoreboard recognises a shortened character when a start bit appears where a high stop bit was due, and it checks the spacing between such events.

// File: rtl/a2s_pkg.sv
package a2s_pkg;
  localparam int unsigned CHAR_MAX = 11;
  localparam int unsigned LEN_W    = 4;

  typedef logic [LEN_W-1:0] len_t;

  typedef enum logic [1:0] {
    FMT_9   = 2'd0,
    FMT_10  = 2'd1,
    FMT_11  = 2'd2,
    FMT_11X = 2'd3
  } fmt_e;

  typedef struct packed {
    len_t                len;
    logic [CHAR_MAX-1:0] bits;
  } char_t;

  function automatic len_t fmt_len(input fmt_e f);
    case (f)
      FMT_9:   return len_t'(9);
      FMT_10:  return len_t'(10);
      default: return len_t'(11);
    endcase
  endfunction
endpackage

// File: rtl/a2s_rx_sampler.sv
module a2s_rx_sampler
  import a2s_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned OVERSAMPLE  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_en,
  input  logic       rx_line,
  input  logic [1:0] len_sel,
  output logic       char_valid,
  output char_t      char_data,
  output logic       frame_err
);
  localparam int unsigned PH_W  = $clog2(OVERSAMPLE);
  localparam int unsigned IDX_W = $clog2(CHAR_MAX);
  localparam logic [PH_W-1:0] PH_MID = PH_W'(OVERSAMPLE / 2 - 1);
  localparam logic [PH_W-1:0] PH_END = PH_W'(OVERSAMPLE - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS} st_e;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line_s;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_line};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= rx_line;
      end
    end
  endgenerate

  assign line_s = sync_q[SYNC_STAGES-1];

  st_e                 st;
  logic                line_prev;
  logic [PH_W-1:0]     ph;
  logic [IDX_W-1:0]    idx;
  logic [CHAR_MAX-1:0] shreg;
  len_t                cur_len;
  logic                last_pos;

  assign last_pos = (len_t'(idx) == cur_len - len_t'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      line_prev  <= 1'b1;
      ph         <= '0;
      idx        <= '0;
      shreg      <= '0;
      cur_len    <= len_t'(9);
      char_valid <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      char_valid <= 1'b0;
      frame_err  <= 1'b0;
      if (baud_en) begin
        line_prev <= line_s;
        case (st)
          S_IDLE: begin
            if (line_prev && !line_s) begin
              st      <= S_START;
              ph      <= '0;
              cur_len <= fmt_len(fmt_e'(len_sel));
            end
          end
          S_START: begin
            if (ph == PH_MID) begin
              ph <= '0;
              if (!line_s) begin
                shreg <= '0;
                idx   <= IDX_W'(1);
                st    <= S_BITS;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              ph <= ph + PH_W'(1);
            end
          end
          S_BITS: begin
            if (ph == PH_END) begin
              ph         <= '0;
              shreg[idx] <= line_s;
              if (last_pos) begin
                char_valid <= 1'b1;
                frame_err  <= !line_s;
                st         <= S_IDLE;
              end else begin
                idx <= idx + IDX_W'(1);
              end
            end else begin
              ph <= ph + PH_W'(1);
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign char_data.len  = cur_len;
  assign char_data.bits = shreg;
endmodule

// File: rtl/a2s_char_fifo.sv
module a2s_char_fifo
  import a2s_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  input  char_t                      wr_data,
  output logic                       wr_ready,
  output logic                       rd_valid,
  output char_t                      rd_data,
  input  logic                       rd_ready,
  output logic [$clog2(DEPTH+1)-1:0] fill,
  output logic                       ovf_evt
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  char_t            slot [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_wr, do_rd;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign wr_ready = (fill != CNT_W'(DEPTH));
  assign rd_valid = (fill != '0);
  assign do_wr    = wr_valid && wr_ready;
  assign do_rd    = rd_valid && rd_ready;
  assign ovf_evt  = wr_valid && !wr_ready;
  assign rd_data  = slot[rd_ptr];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (do_wr && wr_ptr == PTR_W'(i)) slot[i] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      if (do_rd) rd_ptr <= bump(rd_ptr);
      case ({do_wr, do_rd})
        2'b10:   fill <= fill + CNT_W'(1);
        2'b01:   fill <= fill - CNT_W'(1);
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/a2s_bit_serializer.sv
module a2s_bit_serializer
  import a2s_pkg::*;
#(
  parameter int unsigned DEPTH       = 4,
  parameter int unsigned NF_LEVEL    = 3,
  parameter int unsigned DEL_SPACING = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       s_ready,
  input  logic                       rd_valid,
  input  char_t                      rd_data,
  input  logic [$clog2(DEPTH+1)-1:0] fill,
  output logic                       rd_ready,
  output logic                       s_bit,
  output logic                       busy
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned SP_W  = $clog2(DEL_SPACING);
  localparam int unsigned IDX_W = $clog2(CHAR_MAX);
  localparam logic [SP_W-1:0] SP_FULL = SP_W'(DEL_SPACING - 1);

  logic [CHAR_MAX-1:0] shreg;
  logic [IDX_W-1:0]    idx;
  len_t                lim;
  logic [SP_W-1:0]     gap_cnt;
  logic                load, credit, tail_high, drop;

  assign load      = s_ready && !busy && rd_valid;
  assign rd_ready  = load;
  assign credit    = (gap_cnt == SP_FULL);
  assign tail_high = rd_data.bits[rd_data.len - len_t'(1)];
  assign drop      = credit && (fill >= CNT_W'(NF_LEVEL)) && tail_high;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      s_bit   <= 1'b1;
      shreg   <= '0;
      idx     <= '0;
      lim     <= '0;
      gap_cnt <= SP_FULL;
    end else if (s_ready) begin
      if (busy) begin
        s_bit <= shreg[idx];
        idx   <= idx + IDX_W'(1);
        if (len_t'(idx) == lim - len_t'(1)) busy <= 1'b0;
      end else if (rd_valid) begin
        s_bit <= rd_data.bits[0];
        shreg <= rd_data.bits;
        idx   <= IDX_W'(1);
        lim   <= drop ? rd_data.len - len_t'(1) : rd_data.len;
        busy  <= 1'b1;
        if (drop)        gap_cnt <= '0;
        else if (!credit) gap_cnt <= gap_cnt + SP_W'(1);
      end else begin
        s_bit <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/a2s_converter.sv
module a2s_converter
  import a2s_pkg::*;
#(
  parameter int unsigned DEPTH       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned OVERSAMPLE  = 16,
  parameter int unsigned DEL_SPACING = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_en,
  input  logic       rx_line,
  input  logic [1:0] len_sel,
  input  logic       s_ready,
  output logic       s_valid,
  output logic       s_bit,
  output logic       frame_err,
  output logic       ovf_sticky,
  input  logic       ovf_clr
);
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1);
  localparam int unsigned NF_LEVEL = DEPTH - 1;

  logic             char_valid;
  char_t            char_data;
  logic             wr_ready;
  logic             rd_valid;
  char_t            rd_data;
  logic             rd_ready;
  logic [CNT_W-1:0] fifo_fill;
  logic             ovf_evt;
  logic             ser_busy;

  a2s_rx_sampler #(
    .SYNC_STAGES(SYNC_STAGES),
    .OVERSAMPLE (OVERSAMPLE)
  ) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_en   (baud_en),
    .rx_line   (rx_line),
    .len_sel   (len_sel),
    .char_valid(char_valid),
    .char_data (char_data),
    .frame_err (frame_err)
  );

  a2s_char_fifo #(
    .DEPTH(DEPTH)
  ) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_valid(char_valid),
    .wr_data (char_data),
    .wr_ready(wr_ready),
    .rd_valid(rd_valid),
    .rd_data (rd_data),
    .rd_ready(rd_ready),
    .fill    (fifo_fill),
    .ovf_evt (ovf_evt)
  );

  a2s_bit_serializer #(
    .DEPTH      (DEPTH),
    .NF_LEVEL   (NF_LEVEL),
    .DEL_SPACING(DEL_SPACING)
  ) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_ready (s_ready),
    .rd_valid(rd_valid),
    .rd_data (rd_data),
    .fill    (fifo_fill),
    .rd_ready(rd_ready),
    .s_bit   (s_bit),
    .busy    (ser_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_valid    <= 1'b0;
      ovf_sticky <= 1'b0;
    end else begin
      s_valid <= 1'b1;
      if (ovf_evt)      ovf_sticky <= 1'b1;
      else if (ovf_clr) ovf_sticky <= 1'b0;
    end
  end
endmodule

// File: rtl/a2s_converter_chk.sv
module a2s_converter_chk #(
  parameter int unsigned DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       s_ready,
  input logic                       s_bit,
  input logic                       s_valid,
  input logic                       frame_err,
  input logic                       ovf_sticky,
  input logic                       ovf_clr,
  input logic                       ovf_evt,
  input logic [$clog2(DEPTH+1)-1:0] fifo_fill,
  input logic                       rd_valid,
  input logic                       ser_busy
);
  p_bit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ready |=> $stable(s_bit));

  p_mark_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !rd_valid && !ser_busy) |=> s_bit);

  p_ferr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  p_sticky_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_sticky);

  p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_sticky && !ovf_clr) |=> ovf_sticky);

  p_sticky_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !ovf_evt) |=> !ovf_sticky);

  p_fill_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_fill <= ($clog2(DEPTH+1))'(DEPTH));

  p_valid_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |=> s_valid);
endmodule

bind a2s_converter a2s_converter_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_ready   (s_ready),
  .s_bit     (s_bit),
  .s_valid   (s_valid),
  .frame_err (frame_err),
  .ovf_sticky(ovf_sticky),
  .ovf_clr   (ovf_clr),
  .ovf_evt   (ovf_evt),
  .fifo_fill (fifo_fill),
  .rd_valid  (rd_valid),
  .ser_busy  (ser_busy)
);

// File: tb/tb_a2s_converter.sv
`timescale 1ns/1ps
module tb_a2s_converter;
  localparam int DEPTH   = 4;
  localparam int BIT_CLK = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_en = 1'b0;
  logic       rx_line = 1'b1;
  logic [1:0] len_sel = 2'd1;
  logic       s_ready = 1'b0;
  logic       s_valid, s_bit, frame_err, ovf_sticky;
  logic       ovf_clr = 1'b0;

  a2s_converter #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .baud_en(baud_en), .rx_line(rx_line),
    .len_sel(len_sel), .s_ready(s_ready), .s_valid(s_valid), .s_bit(s_bit),
    .frame_err(frame_err), .ovf_sticky(ovf_sticky), .ovf_clr(ovf_clr)
  );

  always #2.5 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard: {len[3:0], bits[10:0]}
  logic [14:0] expq[$];
  int pushed = 0, nrx = 0, ndel = 0, since = 100, fe_cnt = 0;
  bit in_char = 0;
  logic [10:0] cur_bits, got;
  int cur_len = 0, pos = 0;
  bit rdy_on = 0, rdy_was = 0;
  int rperiod = 32, rcnt = 0;

  task automatic begin_char();
    logic [14:0] e;
    if (expq.size() == 0) begin
      chk(1'b0, "R3", "start bit with nothing pending", 0, 1);
    end else begin
      e = expq.pop_front();
      cur_len  = int'(e[14:11]);
      cur_bits = e[10:0];
      got = '0;
      pos = 1;
      in_char = 1;
    end
  endtask

  task automatic take(input logic b);
    logic [10:0] mask;
    if (!in_char) begin
      if (b == 1'b0) begin_char();
    end else if (pos == cur_len - 1 && cur_bits[cur_len-1] && b == 1'b0) begin
      mask = 11'((1 << (cur_len - 1)) - 1);
      chk(((got ^ cur_bits) & mask) == 0, "R6", "shortened body", got, cur_bits);
      chk(since >= 7, "R6", "deletion spacing", since, 7);
      ndel++;
      since = 0;
      nrx++;
      in_char = 0;
      begin_char();
    end else begin
      got[pos] = b;
      pos++;
      if (pos == cur_len) begin
        mask = 11'((1 << cur_len) - 1);
        chk((got & mask) == (cur_bits & mask), cur_bits[cur_len-1] ? "R3" : "R5",
            "character bits", got, cur_bits);
        since++;
        nrx++;
        in_char = 0;
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rdy_was) take(s_bit);
    if (rst_n && frame_err) fe_cnt++;
    baud_en = ~baud_en;
    if (rdy_on) begin
      if (rcnt >= rperiod - 1) begin s_ready = 1'b1; rcnt = 0; end
      else begin s_ready = 1'b0; rcnt++; end
    end else begin
      s_ready = 1'b0;
      rcnt = 0;
    end
    rdy_was = s_ready;
  end

  function automatic logic [10:0] mk(input int len, input logic [9:0] data, input logic stop);
    logic [10:0] v = '0;
    for (int i = 1; i < len - 1; i++) v[i] = data[i-1];
    v[len-1] = stop;
    return v;
  endfunction

  task automatic send_char(input int len, input logic [10:0] bits, input bit push, input int gap);
    if (push) begin
      expq.push_back({4'(len), bits});
      pushed++;
    end
    for (int i = 0; i < len; i++) begin
      rx_line = bits[i];
      repeat (BIT_CLK) @(negedge clk);
    end
    rx_line = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_clks(5);
    // R8 reset state
    chk(s_bit == 1'b1, "R8", "s_bit in reset", s_bit, 1);
    chk(s_valid == 1'b0, "R8", "s_valid in reset", s_valid, 0);
    chk(ovf_sticky == 1'b0, "R8", "ovf in reset", ovf_sticky, 0);
    chk(frame_err == 1'b0, "R8", "frame_err in reset", frame_err, 0);
    rst_n = 1'b1;
    wait_clks(3);
    chk(s_valid == 1'b1, "R8", "s_valid after reset", s_valid, 1);
    rdy_on = 1;
    wait_clks(100);
    chk(s_bit == 1'b1, "R4", "mark while idle", s_bit, 1);

    // R3: 10-bit characters
    len_sel = 2'd1;
    for (int i = 0; i < 4; i++) send_char(10, mk(10, 10'(8'hA5 ^ (i * 8'h3B)), 1'b1), 1, 32);
    wait_clks(800);
    chk(nrx == 4, "R3", "10-bit characters received", nrx, 4);

    // R2: 9 and 11 bit lengths, code 3 too
    len_sel = 2'd0;
    for (int i = 0; i < 4; i++) send_char(9, mk(9, 10'(7'h55 + i * 9), 1'b1), 1, 32);
    len_sel = 2'd2;
    for (int i = 0; i < 4; i++) send_char(11, mk(11, 10'(9'h1C3 ^ (i * 9'h071)), 1'b1), 1, 32);
    len_sel = 2'd3;
    for (int i = 0; i < 2; i++) send_char(11, mk(11, 10'(9'h0F0 + i), 1'b1), 1, 32);
    wait_clks(800);
    chk(nrx == 14, "R2", "mixed-length characters received", nrx, 14);
    chk(fe_cnt == 0, "R5", "no framing error on good stops", fe_cnt, 0);

    // R1: glitch is discarded
    len_sel = 2'd1;
    rx_line = 1'b0;
    wait_clks(6);
    rx_line = 1'b1;
    wait_clks(600);
    chk(nrx == 14 && expq.size() == 0, "R1", "glitch produced no character", nrx, 14);
    chk(s_bit == 1'b1, "R4", "mark after glitch", s_bit, 1);
    rx_line = 1'b0;
    wait_clks(6);
    rx_line = 1'b1;
    wait_clks(20);
    send_char(10, mk(10, 10'h0C9, 1'b1), 1, 32);
    wait_clks(600);
    chk(nrx == 15, "R1", "real start after glitch", nrx, 15);

    // R5: low stop sample
    send_char(10, mk(10, 10'h03C, 1'b0), 1, 64);
    wait_clks(800);
    chk(fe_cnt == 1, "R5", "framing error pulses", fe_cnt, 1);
    chk(nrx == 16, "R5", "errored character forwarded", nrx, 16);

    // R6: overspeed fills the buffer
    rdy_on = 0;
    for (int i = 0; i < 3; i++) send_char(10, mk(10, 10'(8'h11 * (i + 1)), 1'b1), 1, 6);
    rperiod = 33;
    rdy_on = 1;
    for (int i = 0; i < 12; i++) send_char(10, mk(10, 10'(8'h6D ^ (i * 8'h13)), 1'b1), 1, 6);
    wait_clks(5000);
    chk(ndel >= 1, "R6", "stop elements deleted", ndel, 1);
    chk(ovf_sticky == 1'b0, "R7", "no overflow under overspeed", ovf_sticky, 0);
    chk(expq.size() == 0, "R3", "overspeed drained", expq.size(), 0);

    // R7: overflow
    rperiod = 32;
    rdy_on = 0;
    wait_clks(100);
    for (int i = 0; i < DEPTH + 2; i++)
      send_char(10, mk(10, 10'(8'h80 + i * 5), 1'b1), (i < DEPTH), 32);
    wait_clks(100);
    chk(ovf_sticky == 1'b1, "R7", "overflow flag set", ovf_sticky, 1);
    wait_clks(300);
    chk(ovf_sticky == 1'b1, "R7", "overflow flag held", ovf_sticky, 1);
    chk(s_bit == 1'b1, "R3", "output held while stalled", s_bit, 1);
    ovf_clr = 1'b1;
    wait_clks(1);
    ovf_clr = 1'b0;
    wait_clks(2);
    chk(ovf_sticky == 1'b0, "R7", "overflow flag cleared", ovf_sticky, 0);
    rdy_on = 1;
    wait_clks(6000);
    chk(expq.size() == 0, "R7", "stored characters drained", expq.size(), 0);
    chk(nrx == pushed, "R3", "all expected characters seen", nrx, pushed);
    chk(s_bit == 1'b1, "R4", "mark after drain", s_bit, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule